// File: doc/BRIEF.md
# Shared RAM Host Access Port

This block gives a host processor a small byte-wide register window into the shared RAM of an attached coprocessor. The host sees four registers on a 2-bit select: a low address byte, a high address byte, a data port and a control/status byte. The two address bytes together form a 16-bit pointer. Each read or write of the data port reaches the shared RAM at that pointer. When auto-increment is enabled, the pointer steps after every data port access, so a whole block can be streamed in or out after one address load.

The control/status byte holds the coprocessor run enable and the auto-increment enable. It also carries a doorbell that rings the coprocessor. It shows two sticky interrupt flags, which the coprocessor raises and the host clears. One host interrupt line is the OR of the two flags. The shared RAM is part of the block as a dual-port byte RAM, and its second port belongs to the coprocessor. The coprocessor core is not part of the block.

Top module: `shram_host_port`

## Requirements
- R1: Register select 0 writes the low byte of the 16-bit pointer and select 1 writes the high byte; reading select 0 or 1 returns the current low or high pointer byte.
- R2: A data port read (select 2) returns the RAM byte at the pointer on host_rdata in the cycle after the read strobe. A data port write stores host_wdata at the pointer. The RAM is indexed by the low RAM_AW bits of the pointer.
- R3: With auto-increment (control bit 1) set, every data port read or write adds one to the pointer. With it clear, data port accesses leave the pointer unchanged.
- R4: On auto-increment the pointer wraps from 0xFFFF to 0x0000, and a data port read returns the byte at the address before the increment.
- R5: A control write (select 3) loads the run bit from bit 0, and cp_run follows it from the next cycle. Bit 0 of a control read returns it.
- R6: A control write with bit 2 set produces exactly one cycle of cp_doorbell in the cycle after the write. Bit 2 always reads back as 0.
- R7: A pulse on cp_set_int0 or cp_set_int1 sets flag INT0 or INT1, which reads back in control bit 3 or bit 4 respectively, and the flag stays set until the host clears it.
- R8: A control write with a 1 in bit 3 or bit 4 clears INT0 or INT1, and a 0 in that bit leaves the flag unchanged. A set strobe in the same cycle as a clear leaves the flag set.
- R9: host_irq is high exactly while INT0 or INT1 is set.
- R10: The coprocessor port reads and writes the same RAM: cp_rdata shows the byte at cp_addr one cycle after cp_en. Bytes written by either side are visible to the other.
- R11: After reset the pointer is 0, run, auto-increment and both flags are 0, and cp_run, cp_doorbell and host_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 control |
| host_wr | input | 1 | Host write strobe (takes precedence over host_rd) |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid the cycle after host_rd |
| host_irq | output | 1 | Host interrupt, OR of INT0 and INT1 |
| cp_run | output | 1 | Run enable to the coprocessor |
| cp_doorbell | output | 1 | One-cycle doorbell pulse to the coprocessor |
| cp_set_int0 | input | 1 | Coprocessor strobe that sets INT0 |
| cp_set_int1 | input | 1 | Coprocessor strobe that sets INT1 |
| cp_en | input | 1 | Coprocessor RAM access enable |
| cp_we | input | 1 | Coprocessor RAM write enable |
| cp_addr | input | RAM_AW | Coprocessor RAM address |
| cp_wdata | input | DATA_W | Coprocessor RAM write data |
| cp_rdata | output | DATA_W | Coprocessor RAM read data, one cycle latency |

## Verification
The bench walks the pointer across 0xFFFF with auto-increment on. A design that carries into the wrong byte, or that returns the byte after the increment, would read the wrong values after the wrap. It issues a set strobe in the same cycle as a host clear, which catches a design that lets the clear win. It also writes zeros to the flag bits, which catches a design that clears on any control write. It checks that the doorbell lasts exactly one cycle and never reads back, that a data access leaves the pointer alone while auto-increment is off, and that data crosses between the host and coprocessor ports. Random mixes of these operations are compared against a bench model of the pointer, RAM and flags.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {
    SEL_PLO  = 2'd0,
    SEL_PHI  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  localparam int CB_RUN  = 0;
  localparam int CB_AINC = 1;
  localparam int CB_BELL = 2;
  localparam int CB_INT0 = 3;
  localparam int CB_INT1 = 4;
  localparam int CB_USED = 5;
endpackage

// File: rtl/shram_dpram.sv
module shram_dpram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Port A (host) is written last so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  // Reads return the contents held before any write in the same cycle.
  always_ff @(posedge clk) begin
    if (a_en) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/shram_addr_ptr.sv
module shram_addr_ptr #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic            inc,
  input  logic [BW-1:0]   wbyte,
  output logic [2*BW-1:0] ptr
);
  localparam int PW = 2 * BW;

  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr;
    ptr_en = ld_lo | ld_hi | inc;
    if (ld_lo)      ptr_d = {ptr[PW-1:BW], wbyte};
    else if (ld_hi) ptr_d = {wbyte, ptr[BW-1:0]};
    else if (inc)   ptr_d = ptr + {{(PW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [CB_USED-1:0] wbits,
  input  logic               set0,
  input  logic               set1,
  output logic               run,
  output logic               ainc,
  output logic               int0,
  output logic               int1,
  output logic               bell
);
  logic run_d, ainc_d, int0_d, int1_d, bell_d;

  always_comb begin
    run_d  = run;
    ainc_d = ainc;
    if (wr_ctrl) begin
      run_d  = wbits[CB_RUN];
      ainc_d = wbits[CB_AINC];
    end
    // Set beats clear when both arrive together.
    int0_d = (int0 & ~(wr_ctrl & wbits[CB_INT0])) | set0;
    int1_d = (int1 & ~(wr_ctrl & wbits[CB_INT1])) | set1;
    bell_d = wr_ctrl & wbits[CB_BELL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      ainc <= 1'b0;
      int0 <= 1'b0;
      int1 <= 1'b0;
      bell <= 1'b0;
    end else begin
      run  <= run_d;
      ainc <= ainc_d;
      int0 <= int0_d;
      int1 <= int1_d;
      bell <= bell_d;
    end
  end
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
  import shram_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  output logic              cp_run,
  output logic              cp_doorbell,
  input  logic              cp_set_int0,
  input  logic              cp_set_int1,
  input  logic              cp_en,
  input  logic              cp_we,
  input  logic [RAM_AW-1:0] cp_addr,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata
);
  localparam int PTR_W = 2 * DATA_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Access decode: a write wins over a read in the same cycle.
  logic acc_rd, sel_lo, sel_hi, sel_dat, sel_ctl;
  logic dat_acc, dat_wr;

  always_comb begin
    acc_rd  = host_rd & ~host_wr;
    sel_lo  = (host_sel == SEL_PLO);
    sel_hi  = (host_sel == SEL_PHI);
    sel_dat = (host_sel == SEL_DATA);
    sel_ctl = (host_sel == SEL_CTRL);
    dat_wr  = host_wr & sel_dat;
    dat_acc = (host_wr | acc_rd) & sel_dat;
  end

  logic [PTR_W-1:0] ptr;
  logic run_s, ainc_s, int0_s, int1_s, bell_s;

  shram_addr_ptr #(.BW(DATA_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_q),
    .ld_lo (host_wr & sel_lo),
    .ld_hi (host_wr & sel_hi),
    .inc   (dat_acc & ainc_s),
    .wbyte (host_wdata),
    .ptr   (ptr)
  );

  shram_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_ctrl (host_wr & sel_ctl),
    .wbits   (host_wdata[CB_USED-1:0]),
    .set0    (cp_set_int0),
    .set1    (cp_set_int1),
    .run     (run_s),
    .ainc    (ainc_s),
    .int0    (int0_s),
    .int1    (int1_s),
    .bell    (bell_s)
  );

  logic [DATA_W-1:0] ram_q;

  shram_dpram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk     (clk),
    .a_en    (dat_acc),
    .a_we    (dat_wr),
    .a_addr  (ptr[RAM_AW-1:0]),
    .a_wdata (host_wdata),
    .a_rdata (ram_q),
    .b_en    (cp_en),
    .b_we    (cp_we),
    .b_addr  (cp_addr),
    .b_wdata (cp_wdata),
    .b_rdata (cp_rdata)
  );

  // Register readback, captured at the read strobe.
  logic [DATA_W-1:0] ctl_view, reg_d, reg_q;
  logic              rsel_dat_q;

  always_comb begin
    ctl_view          = '0;
    ctl_view[CB_RUN]  = run_s;
    ctl_view[CB_AINC] = ainc_s;
    ctl_view[CB_INT0] = int0_s;
    ctl_view[CB_INT1] = int1_s;
    if (sel_lo)      reg_d = ptr[DATA_W-1:0];
    else if (sel_hi) reg_d = ptr[PTR_W-1:DATA_W];
    else             reg_d = ctl_view;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      reg_q      <= '0;
      rsel_dat_q <= 1'b0;
    end else if (acc_rd) begin
      reg_q      <= reg_d;
      rsel_dat_q <= sel_dat;
    end
  end

  assign host_rdata  = rsel_dat_q ? ram_q : reg_q;
  assign host_irq    = int0_s | int1_s;
  assign cp_run      = run_s;
  assign cp_doorbell = bell_s;
endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk (
  input logic       clk,
  input logic       rst_q,
  input logic [1:0] host_sel,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       host_irq,
  input logic       cp_run,
  input logic       cp_doorbell,
  input logic       cp_set_int0,
  input logic       cp_set_int1
);
  logic ctl_wr;
  assign ctl_wr = host_wr && (host_sel == 2'd3);

  a_r5_run_follows: assert property (@(posedge clk) disable iff (!rst_q)
    ctl_wr |=> (cp_run == $past(host_wdata[0])));

  a_r6_bell_cause: assert property (@(posedge clk) disable iff (!rst_q)
    cp_doorbell |-> $past(ctl_wr && host_wdata[2]));

  a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_q)
    (cp_set_int0 || cp_set_int1) |=> host_irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (host_irq && !ctl_wr) |=> host_irq);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (!host_irq && !cp_set_int0 && !cp_set_int1) |=> !host_irq);
endmodule

bind shram_host_port shram_host_port_chk u_chk (
  .clk         (clk),
  .rst_q       (rst_q),
  .host_sel    (host_sel),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .host_irq    (host_irq),
  .cp_run      (cp_run),
  .cp_doorbell (cp_doorbell),
  .cp_set_int0 (cp_set_int0),
  .cp_set_int1 (cp_set_int1)
);

// File: tb/tb_shram_host_port.sv
module tb_shram_host_port;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_sel;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       host_irq, cp_run, cp_doorbell;
  logic       cp_set_int0, cp_set_int1, cp_en, cp_we;
  logic [7:0] cp_addr, cp_wdata, cp_rdata;

  always #(CLK_P/2) clk = ~clk;

  shram_host_port dut (.*);

  int total = 0;
  int bad   = 0;

  logic [7:0]  mem [DEPTH];
  logic [15:0] m_ptr;
  logic        m_run, m_ai, m_i0, m_i1;

  function automatic logic [7:0] exp_ctl(logic r, logic a, logic i0, logic i1);
    return {3'b000, i1, i0, 1'b0, a, r};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    case (s)
      2'd0: m_ptr[7:0] = d;
      2'd1: m_ptr[15:8] = d;
      2'd2: begin mem[m_ptr[7:0]] = d; if (m_ai) m_ptr++; end
      default: begin
        m_run = d[0]; m_ai = d[1];
        if (d[3]) m_i0 = 1'b0;
        if (d[4]) m_i1 = 1'b0;
      end
    endcase
  endtask

  task automatic hread(logic [1:0] s, output logic [7:0] q);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    q = host_rdata;
  endtask

  task automatic check_read(string req, logic [1:0] s);
    logic [7:0] q, e;
    case (s)
      2'd0: e = m_ptr[7:0];
      2'd1: e = m_ptr[15:8];
      2'd2: e = mem[m_ptr[7:0]];
      default: e = exp_ctl(m_run, m_ai, m_i0, m_i1);
    endcase
    hread(s, q);
    check(req, {8'h00, q}, {8'h00, e});
    if (s == 2'd2 && m_ai) m_ptr++;
  endtask

  task automatic cp_pulse(logic w0, logic w1);
    @(negedge clk);
    cp_set_int0 = w0; cp_set_int1 = w1;
    @(negedge clk);
    cp_set_int0 = 1'b0; cp_set_int1 = 1'b0;
    if (w0) m_i0 = 1'b1;
    if (w1) m_i1 = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; host_sel = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    cp_set_int0 = 0; cp_set_int1 = 0; cp_en = 0; cp_we = 0; cp_addr = '0; cp_wdata = '0;
    m_ptr = '0; m_run = 0; m_ai = 0; m_i0 = 0; m_i1 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 irq", {15'd0, host_irq}, 16'd0);
    check("R11 run", {15'd0, cp_run}, 16'd0);
    check("R11 bell", {15'd0, cp_doorbell}, 16'd0);
    check_read("R11 ctrl", 2'd3);
    check_read("R11 ptr lo", 2'd0);

    // R3 fill the whole RAM after one address load, streaming
    hwrite(2'd3, 8'h02);
    hwrite(2'd0, 8'h00);
    for (int i = 0; i < DEPTH; i++) hwrite(2'd2, 8'(i * 7 + 3));
    check_read("R3 ptr after stream lo", 2'd0);
    check_read("R3 ptr after stream hi", 2'd1);
    hwrite(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) check_read("R2 R3 stream read", 2'd2);

    // R1 address load and readback
    hwrite(2'd0, 8'h5A);
    hwrite(2'd1, 8'hC3);
    check_read("R1 lo", 2'd0);
    check_read("R1 hi", 2'd1);

    // R3 no increment when disabled
    hwrite(2'd3, 8'h00);
    hwrite(2'd2, 8'hEE);
    check_read("R2 data", 2'd2);
    check_read("R3 ptr held", 2'd0);

    // R4 wrap across 0xFFFF, read returns pre-increment byte
    hwrite(2'd3, 8'h02);
    hwrite(2'd0, 8'hFF);
    hwrite(2'd1, 8'hFF);
    check_read("R4 read at FFFF", 2'd2);
    check_read("R4 wrap lo", 2'd0);
    check_read("R4 wrap hi", 2'd1);

    // R5 run bit
    hwrite(2'd3, 8'h03);
    check("R5 run set", {15'd0, cp_run}, 16'd1);
    check_read("R5 ctrl", 2'd3);

    // R6 doorbell: one-cycle pulse, never read back
    @(negedge clk);
    host_sel = 2'd3; host_wr = 1'b1; host_wdata = 8'h07;
    @(negedge clk);
    host_wr = 1'b0;
    check("R6 bell high", {15'd0, cp_doorbell}, 16'd1);
    @(negedge clk);
    check("R6 bell low", {15'd0, cp_doorbell}, 16'd0);
    check_read("R6 bell reads 0", 2'd3);

    // R7 R9 flags set and sticky
    cp_pulse(1'b1, 1'b0);
    check("R9 irq from int0", {15'd0, host_irq}, 16'd1);
    repeat (3) @(negedge clk);
    check_read("R7 int0 sticky", 2'd3);
    cp_pulse(1'b0, 1'b1);
    check_read("R7 both", 2'd3);

    // R8 write 0 leaves flags, write 1 clears one
    hwrite(2'd3, 8'h03);
    check_read("R8 zero keeps", 2'd3);
    hwrite(2'd3, 8'h0B);
    check_read("R8 clear int0", 2'd3);
    check("R9 irq int1 only", {15'd0, host_irq}, 16'd1);
    hwrite(2'd3, 8'h13);
    check("R9 irq low", {15'd0, host_irq}, 16'd0);

    // R8 set and clear in the same cycle: set wins
    @(negedge clk);
    host_sel = 2'd3; host_wr = 1'b1; host_wdata = 8'h1B; cp_set_int0 = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; cp_set_int0 = 1'b0;
    m_i0 = 1'b1; m_i1 = 1'b0;
    check_read("R8 set beats clear", 2'd3);
    hwrite(2'd3, 8'h1B);
    check("R9 irq cleared", {15'd0, host_irq}, 16'd0);

    // R10 coprocessor reads a host byte, writes one the host reads
    @(negedge clk);
    cp_en = 1'b1; cp_addr = 8'h40;
    @(negedge clk);
    cp_en = 1'b0;
    check("R10 cp read", {8'h00, cp_rdata}, {8'h00, mem[8'h40]});
    @(negedge clk);
    cp_en = 1'b1; cp_we = 1'b1; cp_addr = 8'h41; cp_wdata = 8'hA5;
    @(negedge clk);
    cp_en = 1'b0; cp_we = 1'b0;
    mem[8'h41] = 8'hA5;
    hwrite(2'd0, 8'h41);
    hwrite(2'd1, 8'h00);
    check_read("R10 host sees cp byte", 2'd2);

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: hwrite(2'd0, 8'($urandom));
        1: hwrite(2'd1, 8'($urandom));
        2, 3: hwrite(2'd2, 8'($urandom));
        4, 5: check_read("R2 R3 random data", 2'd2);
        6: hwrite(2'd3, 8'($urandom) & 8'h1B);
        7: cp_pulse(1'($urandom), 1'($urandom));
        8: check_read("R7 R8 random ctrl", 2'd3);
        default: check_read("R1 random ptr", 2'($urandom_range(0, 1)));
      endcase
      check("R9 random irq", {15'd0, host_irq}, {15'd0, m_i0 | m_i1});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule